// File: doc/BRIEF.md
# Audio Serial Output Port

This block takes stereo audio samples from a receiver (a left and a right word, an error flag and a lock indication) and sends them on a three-wire serial link: bit clock, frame sync and data. In master mode the block makes the bit clock and frame sync itself by dividing the system clock. In slave mode an external device drives both, and the block follows them. A frame is 64 bit periods long. The left word uses the first 32 slots, while frame sync is high. The right word uses the last 32 slots, while frame sync is low.

A 4-bit layout code selects the word width, the bit order and where the word sits in its 32-slot half. One code is reserved and sends silence. One code parks the port, with all of its outputs low. An optional repeat mode covers bad samples: an errored sample is replaced by the previous good one, and the port sends silence while the receiver is unlocked. In slave mode the block watches whether the external frame rate matches the sample rate. When a sample is skipped or sent twice, it raises a sticky flag, and a status read clears that flag.

Top module: `aso_port`

## Requirements
- R1: With `launch_fall`=1 the data line changes only on a falling bit-clock edge; with `launch_fall`=0 only on a rising edge. In master mode data never changes without such an edge while the layout code and mode are steady.
- R2: Frame sync is high for the 32 slots of the left word and low for the 32 slots of the right word. A word sampled at the start of a frame is sent whole in that frame. In master mode frame sync is high for exactly half the frame (128 system clocks at the default divide).
- R3: Layout codes (slot 0 is the first slot after a frame-sync change; words are 18-bit, and 16-bit layouts send bits 17..2). Code 0: 16 bits, MSB first, in slots 0-15. Code 1: 18 bits, MSB first, in slots 0-17. Code 2: 16 bits, MSB first, in slots 16-31. Code 3: 18 bits, MSB first, in slots 14-31. Code 4: 16 bits, LSB first (bit 2 first), in slots 0-15. Code 5: 18 bits, LSB first, in slots 0-17. All other slots are 0.
- R4: With `rep_en`=1 and the receiver locked, a sample taken with `smp_err`=1 is discarded, and the previous good word is sent in its place.
- R5: With `rep_en`=1 and `locked`=0, all-zero words are sent.
- R6: With `rep_en`=0 every sample is sent as given, whatever the error and lock inputs are.
- R7: In slave mode, after the first sample, a frame start that saw no new sample or more than one new sample sets `slip_o`. The flag stays set until it is cleared.
- R8: `slip_o` is never set while master mode is selected.
- R9: A one-cycle `stat_rd` pulse clears `slip_o` when no slip event happens in the same cycle.
- R10: Layout code 14 is reserved. The data line stays low and the bit clock keeps running.
- R11: Layout code 15 puts the port in reset. From the next cycle on, `sck_o`, `fsync_o` and `sdata_o` are low.
- R12: After code 15 is replaced by another code, the outputs stay low until a `blk_start` pulse arrives. A `blk_start` pulse while the code is still 15 has no effect.
- R13: In master mode the bit-clock period is 2*HALF_DIV system clocks (4 at the default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (256 times the sample rate in master mode) |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt | input | 4 | Serial layout code |
| master_en | input | 1 | 1: port drives bit clock and frame sync; 0: follows inputs |
| launch_fall | input | 1 | Edge select for data changes (1 falling, 0 rising) |
| rep_en | input | 1 | Repeat-last-good-sample and mute-on-unlock enable |
| smp_valid | input | 1 | One-cycle strobe for a new sample pair |
| smp_left | input | 18 | Left sample word |
| smp_right | input | 18 | Right sample word |
| smp_err | input | 1 | Error flag for the strobed sample |
| locked | input | 1 | Receiver lock indication |
| blk_start | input | 1 | Pulse at a channel-status block boundary |
| sck_in | input | 1 | External bit clock (slave mode) |
| fsync_in | input | 1 | External frame sync (slave mode) |
| stat_rd | input | 1 | Status read strobe, clears the slip flag |
| sck_o | output | 1 | Generated bit clock (master mode, else low) |
| fsync_o | output | 1 | Generated frame sync (master mode, else low) |
| sdata_o | output | 1 | Serial data |
| slip_o | output | 1 | Sticky slip flag |

## Verification
The hardest condition to reach is a slip, because it needs a drift between two timebases that the port does not control. The bench drives its own slave bit clock, which makes one frame every 512 system clocks. It then sends samples at periods shorter and longer than 512 clocks, so that some frames see two new samples and others see none, and it checks that the flag sets, stays set and clears on a read. Leaving the parked layout also needs care: the stimulus changes the code first, holds it for several hundred cycles with no block boundary, and only then pulses `blk_start`.

// File: rtl/aso_pkg.sv
package aso_pkg;
    // Layout codes
    localparam logic [3:0] FMT_MSB_L16 = 4'd0;
    localparam logic [3:0] FMT_MSB_L18 = 4'd1;
    localparam logic [3:0] FMT_MSB_R16 = 4'd2;
    localparam logic [3:0] FMT_MSB_R18 = 4'd3;
    localparam logic [3:0] FMT_LSB_L16 = 4'd4;
    localparam logic [3:0] FMT_LSB_L18 = 4'd5;
    localparam logic [3:0] FMT_RSVD    = 4'd14;
    localparam logic [3:0] FMT_PARK    = 4'd15;

    typedef struct packed {
        logic [1:0] cnt;     // samples seen since last frame start (saturating)
        logic       primed;  // at least one sample seen
        logic       slip;    // sticky flag
    } slip_st_t;
endpackage

// File: rtl/aso_hold.sv
module aso_hold #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         rep_en,
    input  logic         err,
    input  logic         locked,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) begin
            if (rep_en && !locked)   val_d = '0;
            else if (rep_en && err)  val_d = val_q;
            else                     val_d = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign dout = val_q;
endmodule

// File: rtl/aso_timer.sv
module aso_timer #(
    parameter  int SLOT_W   = 32,
    parameter  int HALF_DIV = 2,
    localparam int POS_W    = $clog2(2 * SLOT_W),
    localparam int DIV_W    = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             master_en,
    input  logic             launch_fall,
    input  logic             sck_in,
    input  logic             fsync_in,
    output logic             frame_start,
    output logic [POS_W-1:0] pos_o,
    output logic             sck_o,
    output logic             fsync_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             sck;
        logic [POS_W-1:0] pos;
        logic             sck_s;
        logic             fs_s;
        logic             sck_p;
        logic             fs_last;
    } tm_t;

    tm_t  st_d, st_q;
    logic launch;

    always_comb begin
        st_d       = st_q;
        st_d.sck_s = sck_in;
        st_d.fs_s  = fsync_in;
        st_d.sck_p = st_q.sck_s;
        launch     = 1'b0;
        if (!run) begin
            st_d.div     = '0;
            st_d.sck     = 1'b0;
            st_d.pos     = '1;
            st_d.fs_last = 1'b0;
        end else if (master_en) begin
            if (st_q.div == DIV_W'(HALF_DIV - 1)) begin
                st_d.div = '0;
                st_d.sck = ~st_q.sck;
                launch   = (~st_q.sck) != launch_fall;
            end else begin
                st_d.div = st_q.div + DIV_W'(1);
            end
            if (launch) st_d.pos = st_q.pos + POS_W'(1);
        end else begin
            launch = (st_q.sck_s != st_q.sck_p) && (st_q.sck_s != launch_fall);
            if (launch) begin
                if (st_q.fs_s != st_q.fs_last) begin
                    st_d.pos     = {~st_q.fs_s, {(POS_W-1){1'b0}}};
                    st_d.fs_last = st_q.fs_s;
                end else if (!(&st_q.pos[POS_W-2:0])) begin
                    st_d.pos = st_q.pos + POS_W'(1);
                end
            end
        end
        frame_start = launch && (st_d.pos == '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pos <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos_o   = st_q.pos;
    assign sck_o   = run & master_en & st_q.sck;
    assign fsync_o = run & master_en & ~st_q.pos[POS_W-1];
endmodule

// File: rtl/aso_slip.sv
module aso_slip
    import aso_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic smp_valid,
    input  logic slave_en,
    input  logic clr,
    output logic slip
);
    slip_st_t st_d, st_q;
    logic     event_hit;

    always_comb begin
        st_d      = st_q;
        event_hit = 1'b0;
        if (smp_valid) st_d.primed = 1'b1;
        if (frame_start) begin
            event_hit = slave_en && st_q.primed && (st_q.cnt != 2'd1);
            st_d.cnt  = {1'b0, smp_valid};
        end else if (smp_valid && st_q.cnt != 2'd2) begin
            st_d.cnt = st_q.cnt + 2'd1;
        end
        if (event_hit)  st_d.slip = 1'b1;
        else if (clr)   st_d.slip = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign slip = st_q.slip;
endmodule

// File: rtl/aso_port.sv
module aso_port
    import aso_pkg::*;
#(
    parameter  int SAMPLE_W = 18,
    parameter  int SLOT_W   = 32,
    parameter  int HALF_DIV = 2,
    localparam int POS_W    = $clog2(2 * SLOT_W),
    localparam int SLOT_LW  = POS_W - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [3:0]          fmt,
    input  logic                master_en,
    input  logic                launch_fall,
    input  logic                rep_en,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    input  logic                smp_err,
    input  logic                locked,
    input  logic                blk_start,
    input  logic                sck_in,
    input  logic                fsync_in,
    input  logic                stat_rd,
    output logic                sck_o,
    output logic                fsync_o,
    output logic                sdata_o,
    output logic                slip_o
);
    typedef struct packed {
        logic                in_rst;
        logic [SAMPLE_W-1:0] fr_l;
        logic [SAMPLE_W-1:0] fr_r;
    } top_t;

    top_t st_d, st_q;

    logic [1:0][SAMPLE_W-1:0] smp_in;
    logic [1:0][SAMPLE_W-1:0] hold;
    logic [SAMPLE_W-1:0]      hold_l, hold_r;
    logic                     run;
    logic                     frame_start;
    logic [POS_W-1:0]         pos;

    assign smp_in[0] = smp_left;
    assign smp_in[1] = smp_right;
    assign run       = ~st_q.in_rst;

    for (genvar c = 0; c < 2; c++) begin : g_ch
        aso_hold #(.W(SAMPLE_W)) u_hold (
            .clk    (clk),
            .rst_n  (rst_n),
            .load   (smp_valid),
            .rep_en (rep_en),
            .err    (smp_err),
            .locked (locked),
            .din    (smp_in[c]),
            .dout   (hold[c])
        );
    end

    assign hold_l = hold[0];
    assign hold_r = hold[1];

    aso_timer #(.SLOT_W(SLOT_W), .HALF_DIV(HALF_DIV)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (run),
        .master_en   (master_en),
        .launch_fall (launch_fall),
        .sck_in      (sck_in),
        .fsync_in    (fsync_in),
        .frame_start (frame_start),
        .pos_o       (pos),
        .sck_o       (sck_o),
        .fsync_o     (fsync_o)
    );

    aso_slip u_slip (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .smp_valid   (smp_valid),
        .slave_en    (~master_en),
        .clr         (stat_rd),
        .slip        (slip_o)
    );

    // Park state and frame snapshot
    always_comb begin
        st_d = st_q;
        if (fmt == FMT_PARK)  st_d.in_rst = 1'b1;
        else if (blk_start)   st_d.in_rst = 1'b0;
        if (st_q.in_rst) begin
            st_d.fr_l = '0;
            st_d.fr_r = '0;
        end else if (frame_start) begin
            st_d.fr_l = hold[0];
            st_d.fr_r = hold[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Slot-to-bit mapping
    int                  sel_b, sel_w, sel_k, sel_i;
    logic                sel_in, sel_rj, sel_lsb, sel_bit;
    logic [SAMPLE_W-1:0] sel_word;

    always_comb begin
        sel_b    = 32'(pos[SLOT_LW-1:0]);
        sel_word = pos[POS_W-1] ? st_q.fr_r : st_q.fr_l;
        sel_w    = fmt[0] ? SAMPLE_W : SAMPLE_W - 2;
        sel_rj   = (fmt == FMT_MSB_R16) || (fmt == FMT_MSB_R18);
        sel_lsb  = (fmt == FMT_LSB_L16) || (fmt == FMT_LSB_L18);
        if (sel_rj) begin
            sel_in = sel_b >= (SLOT_W - sel_w);
            sel_k  = sel_b - (SLOT_W - sel_w);
        end else begin
            sel_in = sel_b < sel_w;
            sel_k  = sel_b;
        end
        sel_i   = sel_lsb ? (SAMPLE_W - sel_w) + sel_k : SAMPLE_W - 1 - sel_k;
        sel_bit = 1'b0;
        for (int i = 0; i < SAMPLE_W; i++) begin
            if (sel_in && i == sel_i) sel_bit = sel_word[i];
        end
    end

    assign sdata_o = run && (fmt <= FMT_LSB_L18) && sel_bit;
endmodule

// File: rtl/aso_chk.sv
module aso_chk #(
    parameter int SAMPLE_W = 18
) (
    input logic                clk,
    input logic                rst_n,
    input logic [3:0]          fmt,
    input logic                master_en,
    input logic                launch_fall,
    input logic                rep_en,
    input logic                smp_valid,
    input logic                smp_err,
    input logic                locked,
    input logic                stat_rd,
    input logic                sck_o,
    input logic                fsync_o,
    input logic                sdata_o,
    input logic                slip_o,
    input logic                frame_start,
    input logic [SAMPLE_W-1:0] hold_l,
    input logic [SAMPLE_W-1:0] hold_r
);
    assert_launch_edge_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && $stable(master_en) && $stable(fmt) && $stable(launch_fall) && $changed(sdata_o))
        |-> (sck_o != $past(sck_o) && sck_o != launch_fall));

    assert_hold_on_err_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && rep_en && smp_err && locked) |=> ($stable(hold_l) && $stable(hold_r)));

    assert_zero_unlock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid && rep_en && !locked) |=> (hold_l == '0 && hold_r == '0));

    assert_no_slip_master_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (master_en && !slip_o) |=> !slip_o);

    assert_slip_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !frame_start) |=> !slip_o);

    assert_reserved_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 4'd14) |-> !sdata_o);

    assert_park_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt == 4'd15) |=> (!sck_o && !fsync_o && !sdata_o));
endmodule

bind aso_port aso_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .fmt         (fmt),
    .master_en   (master_en),
    .launch_fall (launch_fall),
    .rep_en      (rep_en),
    .smp_valid   (smp_valid),
    .smp_err     (smp_err),
    .locked      (locked),
    .stat_rd     (stat_rd),
    .sck_o       (sck_o),
    .fsync_o     (fsync_o),
    .sdata_o     (sdata_o),
    .slip_o      (slip_o),
    .frame_start (frame_start),
    .hold_l      (hold_l),
    .hold_r      (hold_r)
);

// File: tb/sim_aso_port.sv
module sim_aso_port;
    logic clk = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic        rst_n = 1'b0;
    logic [3:0]  fmt = 4'd0;
    logic        master_en = 1'b1, launch_fall = 1'b0, rep_en = 1'b0;
    logic        smp_valid = 1'b0, smp_err = 1'b0, locked = 1'b1;
    logic [17:0] smp_left = '0, smp_right = '0;
    logic        blk_start = 1'b0, sck_drv = 1'b0, fsync_drv = 1'b0, stat_rd = 1'b0;
    logic        sck_o, fsync_o, sdata_o, slip_o;

    aso_port u0 (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .master_en(master_en),
        .launch_fall(launch_fall), .rep_en(rep_en), .smp_valid(smp_valid),
        .smp_left(smp_left), .smp_right(smp_right), .smp_err(smp_err),
        .locked(locked), .blk_start(blk_start), .sck_in(sck_drv),
        .fsync_in(fsync_drv), .stat_rd(stat_rd), .sck_o(sck_o),
        .fsync_o(fsync_o), .sdata_o(sdata_o), .slip_o(slip_o)
    );

    int n_checks = 0, n_err = 0;

    task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // Expected slot pattern of one 32-slot half (index = slot number)
    function automatic logic [31:0] exp_slot(input logic [3:0] f, input logic [17:0] s);
        logic [31:0] v;
        v = '0;
        for (int b = 0; b < 32; b++) begin
            case (f)
                4'd0: if (b < 16)  v[b] = s[17-b];
                4'd1: if (b < 18)  v[b] = s[17-b];
                4'd2: if (b >= 16) v[b] = s[17-(b-16)];
                4'd3: if (b >= 14) v[b] = s[17-(b-14)];
                4'd4: if (b < 16)  v[b] = s[2+b];
                4'd5: if (b < 18)  v[b] = s[b];
                default: ;
            endcase
        end
        return v;
    endfunction

    // Sample feeder
    logic        feed_on = 1'b0;
    int          feed_period = 256;
    logic [17:0] cur_l = '0, cur_r = '0;
    logic        cur_err = 1'b0;
    initial begin
        forever begin
            if (feed_on) begin
                repeat (feed_period - 1) @(posedge clk);
                #1;
                smp_valid = 1'b1; smp_left = cur_l; smp_right = cur_r; smp_err = cur_err;
                @(posedge clk);
                #1;
                smp_valid = 1'b0;
            end else begin
                @(posedge clk);
            end
        end
    end

    // Slave clock generator: 8 system clocks per bit, 64 bits per frame
    logic slv_on = 1'b0;
    initial begin
        forever begin
            if (slv_on) begin
                for (int bit_i = 0; bit_i < 64; bit_i++) begin
                    @(posedge clk); #2;
                    sck_drv = ~launch_fall;
                    fsync_drv = (bit_i < 32);
                    repeat (4) @(posedge clk); #2;
                    sck_drv = launch_fall;
                    repeat (3) @(posedge clk);
                end
            end else begin
                @(posedge clk);
            end
        end
    end

    // Receiving monitor: latches data on the edge opposite the launch edge
    logic        mon_sck, mon_fs, prev_sck = 1'b0, prev_fs = 1'b0, saw_right = 1'b0;
    int          bidx = 0, frames = 0;
    logic [31:0] sh_l = '0, sh_r = '0, cap_l = '0, cap_r = '0;
    always @(negedge clk) begin
        mon_sck = master_en ? sck_o : sck_drv;
        mon_fs  = master_en ? fsync_o : fsync_drv;
        if (mon_sck != prev_sck && mon_sck == launch_fall) begin
            if (mon_fs != prev_fs) begin
                bidx = 0;
                if (mon_fs && saw_right) begin
                    cap_l = sh_l; cap_r = sh_r; frames++; saw_right = 1'b0;
                end
                if (!mon_fs) saw_right = 1'b1;
            end
            if (bidx < 32) begin
                if (mon_fs) sh_l[bidx] = sdata_o;
                else        sh_r[bidx] = sdata_o;
            end
            bidx++;
            prev_fs = mon_fs;
        end
        prev_sck = mon_sck;
    end

    task automatic wait_frames(input int n);
        int f0;
        f0 = frames;
        while (frames < f0 + n) @(posedge clk);
        #1;
    endtask

    task automatic check_frame(input string req, input logic [3:0] f, input logic [17:0] l, input logic [17:0] r);
        chk(req, cap_l == exp_slot(f, l), {32'd0, cap_l}, {32'd0, exp_slot(f, l)});
        chk(req, cap_r == exp_slot(f, r), {32'd0, cap_r}, {32'd0, exp_slot(f, r)});
    endtask

    task automatic pulse_rd();
        stat_rd = 1'b1; step(1); stat_rd = 1'b0;
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset_state();
        @(negedge clk);
        chk("R7 reset slip low", slip_o == 1'b0, slip_o, 0);
        chk("R2 reset data low", sdata_o == 1'b0, sdata_o, 0);
        #4;
    endtask

    task automatic t_layouts();
        for (int f = 0; f < 6; f++) begin
            fmt = 4'(f);
            cur_l = 18'h2A5C3; cur_r = 18'h15A3C;
            wait_frames(3);
            check_frame("R3 R2 layout", 4'(f), cur_l, cur_r);
        end
        fmt = 4'd2; cur_l = 18'h3FFFF; cur_r = 18'h00001;
        wait_frames(3);
        check_frame("R3 right-justified extremes", 4'd2, cur_l, cur_r);
        fmt = 4'd5; cur_l = 18'h20001; cur_r = 18'h1FFFE;
        wait_frames(3);
        check_frame("R3 lsb-first extremes", 4'd5, cur_l, cur_r);
    endtask

    task automatic t_edges(input logic lf);
        int bad, fs_hi, rises;
        logic ps, pd;
        launch_fall = lf; fmt = 4'd1; cur_l = 18'h2AAAA; cur_r = 18'h15555;
        wait_frames(3);
        check_frame("R1 data with edge select", 4'd1, cur_l, cur_r);
        bad = 0; fs_hi = 0; rises = 0;
        @(negedge clk);
        ps = sck_o; pd = sdata_o;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            if (sdata_o != pd && !(sck_o != ps && sck_o != lf)) bad++;
            if (fsync_o) fs_hi++;
            if (sck_o && !ps) rises++;
            ps = sck_o; pd = sdata_o;
        end
        #4;
        chk("R1 data changes only on launch edge", bad == 0, bad, 0);
        chk("R2 frame sync high half frame", fs_hi == 128, fs_hi, 128);
        chk("R13 bit clock period", rises == 64, rises, 64);
    endtask

    task automatic t_repeat();
        launch_fall = 1'b0; fmt = 4'd1;
        rep_en = 1'b1; locked = 1'b1; cur_err = 1'b0;
        cur_l = 18'h12345; cur_r = 18'h2BCDE;
        wait_frames(3);
        check_frame("R4 good sample baseline", 4'd1, 18'h12345, 18'h2BCDE);
        cur_l = 18'h3F00F; cur_r = 18'h00FF0; cur_err = 1'b1;
        wait_frames(3);
        check_frame("R4 errored sample replaced by last good", 4'd1, 18'h12345, 18'h2BCDE);
        cur_err = 1'b0;
        wait_frames(3);
        check_frame("R4 good sample after error", 4'd1, 18'h3F00F, 18'h00FF0);
        rep_en = 1'b0; cur_err = 1'b1; cur_l = 18'h0C3A5; cur_r = 18'h31111;
        wait_frames(3);
        check_frame("R6 errored sample passes without repeat", 4'd1, 18'h0C3A5, 18'h31111);
        rep_en = 1'b1; cur_err = 1'b0; locked = 1'b0;
        wait_frames(3);
        check_frame("R5 unlocked gives zero words", 4'd1, 18'h0, 18'h0);
        rep_en = 1'b0;
        wait_frames(3);
        check_frame("R6 unlocked passes without repeat", 4'd1, 18'h0C3A5, 18'h31111);
        locked = 1'b1;
    endtask

    task automatic t_reserved();
        int ones, toggles;
        logic ps;
        fmt = 4'd14; cur_l = 18'h3FFFF; cur_r = 18'h3FFFF;
        wait_frames(2);
        ones = 0; toggles = 0; ps = sck_o;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (sdata_o) ones++;
            if (sck_o != ps) toggles++;
            ps = sck_o;
        end
        #4;
        chk("R10 reserved code keeps data low", ones == 0, ones, 0);
        chk("R10 reserved code keeps bit clock", toggles > 100, toggles, 150);
    endtask

    task automatic quiet_count(input int n, output int act);
        act = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sck_o || fsync_o || sdata_o) act++;
        end
        #4;
    endtask

    task automatic t_park();
        int act, toggles;
        logic ps;
        cur_l = 18'h3FFFF; cur_r = 18'h2AAAA;
        fmt = 4'd15; step(1);
        quiet_count(300, act);
        chk("R11 park code silences outputs", act == 0, act, 0);
        blk_start = 1'b1; step(1); blk_start = 1'b0;
        quiet_count(300, act);
        chk("R12 block pulse while parked ignored", act == 0, act, 0);
        fmt = 4'd1;
        quiet_count(400, act);
        chk("R12 stays parked until block boundary", act == 0, act, 0);
        blk_start = 1'b1; step(1); blk_start = 1'b0;
        toggles = 0; ps = sck_o;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sck_o != ps) toggles++;
            ps = sck_o;
        end
        #4;
        chk("R12 resumes after block boundary", toggles > 0, toggles, 20);
        wait_frames(3);
        check_frame("R12 data after resume", 4'd1, 18'h3FFFF, 18'h2AAAA);
    endtask

    task automatic t_master_slip();
        master_en = 1'b1; fmt = 4'd0; feed_period = 200;
        step(10); pulse_rd();
        wait_frames(5);
        chk("R8 no slip in master mode", slip_o == 1'b0, slip_o, 0);
        feed_period = 256;
    endtask

    task automatic t_slave();
        master_en = 1'b0; slv_on = 1'b1; fmt = 4'd1; launch_fall = 1'b0;
        feed_period = 512; cur_l = 18'h1E3C7; cur_r = 18'h2961B;
        wait_frames(4);
        check_frame("R2 slave frame data", 4'd1, cur_l, cur_r);
        pulse_rd();
        wait_frames(4);
        chk("R7 no slip when rates match", slip_o == 1'b0, slip_o, 0);
        feed_period = 448;
        wait_frames(4);
        chk("R7 slip on dropped sample", slip_o == 1'b1, slip_o, 1);
        feed_period = 512;
        wait_frames(3);
        chk("R7 slip flag sticky", slip_o == 1'b1, slip_o, 1);
        pulse_rd(); step(1);
        chk("R9 status read clears slip", slip_o == 1'b0, slip_o, 0);
        wait_frames(3);
        chk("R9 stays clear when rates match", slip_o == 1'b0, slip_o, 0);
        feed_period = 600;
        wait_frames(5);
        chk("R7 slip on repeated sample", slip_o == 1'b1, slip_o, 1);
        feed_period = 512;
        step(2); pulse_rd();
        slv_on = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", frames, 0);
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        step(5);
        rst_n = 1'b1;
        t_reset_state();
        feed_on = 1'b1; feed_period = 256;
        t_layouts();
        t_edges(1'b0);
        t_edges(1'b1);
        t_repeat();
        t_reserved();
        t_park();
        t_master_slip();
        t_slave();
        $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end
endmodule